// File: doc/BRIEF.md
# Half-Flash Converter Sampling Sequencer

This block runs the conversion handshake of an external 10-bit half-flash analog-to-digital converter that measures DC bus current in a motor drive. A trigger pulse, issued once per PWM carrier period (10 kHz in the target drive), starts a conversion. The block pulls the converter's active-low sample/hold and read strobes low on the same clock edge, then waits for the converter's active-low completion line to fall. That line arrives roughly 850 ns later. The block then waits a programmable settle time so the output bus carries the new word; the bus holds the previous result until completion is signalled, and the converter needs about 20 ns more to drive the new data. Only then is the word latched into a result register. A one-cycle valid pulse marks the new result.

The completion line is asynchronous, so it passes through a synchronizer before the state machine sees it. Only a high-to-low transition counts as completion, so a line that is stuck low cannot be taken for a finished conversion. A watchdog counter ends a conversion that never completes, returns the strobes high and raises a one-cycle error pulse. Triggers that arrive while a conversion is in flight have no effect.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both strobes (`sh_n`, `rd_n`) are high, `valid` and `err` are low and `result` is zero.
- R2: A high `trig` sampled in the idle state drives `sh_n` and `rd_n` low together from the next rising clock edge.
- R3: Completion is accepted only on a high-to-low transition of the synchronized `int_n` during the wait phase. An `int_n` that is already low when the conversion starts produces a timeout and no result.
- R4: `valid` rises exactly SYNC_STAGES + SETTLE_CYC + 2 rising clock edges after the last rising edge before `int_n` falls. `result` then equals the word present on `adc_data` after completion, not the word present before it.
- R5: `valid` is high for exactly one cycle, and both strobes return high on the same edge at which `valid` rises.
- R6: `result` keeps its value until the next capture, even when `adc_data` changes after the strobes return high.
- R7: If no completion is seen, the strobes stay low for exactly TIMEOUT_CYC + 1 cycles. They then return high together with a one-cycle `err` pulse, and `valid` stays low.
- R8: A `trig` that arrives while a conversion is in progress is ignored: it yields no second conversion and no second `valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Conversion request, one pulse per PWM carrier period |
| int_n | input | 1 | Converter completion line, active low, asynchronous |
| adc_data | input | DATA_W | Converter output bus |
| sh_n | output | 1 | Sample/hold strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| result | output | DATA_W | Last captured conversion word |
| valid | output | 1 | One-cycle pulse marking a new result |
| err | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The hardest case to reach from the ports is a completion line that is already low when a conversion begins. A level-sensitive design would accept this at once, but the block must run to timeout. The bench forces the responder's completion line low while idle, keeps it silent, and then triggers. A second hard case is stale data: the behavioural converter drives the complement of the coming word until completion, and changes the bus only a few nanoseconds after completion falls. A sweep over all 1024 codes, with completion delays that vary per code, therefore catches any latch that happens too early, and also pins the exact latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_INT,
        ST_SETTLE,
        ST_CAPTURE
    } seq_state_t;

    // Events passed from the sequencer to the result stage.
    typedef struct packed {
        logic take;
        logic timeout;
    } seq_evt_t;

    localparam int unsigned DEF_DATA_W      = 10;
    localparam int unsigned DEF_SETTLE_CYC  = 3;
    localparam int unsigned DEF_TIMEOUT_CYC = 200;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int unsigned STAGES = adc_seq_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic level_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= async_n;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[gi] <= 1'b1;
                else     chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[STAGES-1];
    end

    assign level_n = chain[STAGES-1];
    assign fall    = prev_q & ~chain[STAGES-1];

    // R3: a reported fall means the synchronized line is low now and was high one cycle earlier
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        fall |-> (!level_n && $past(level_n)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYC  = DEF_SETTLE_CYC,
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trig,
    input  logic     int_fall,
    output logic     strobe_n,
    output seq_evt_t evt
);
    localparam int unsigned MAX_CNT = max_u(SETTLE_CYC, TIMEOUT_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tmo_d;

    always_comb begin
        state_d = state_q;
        tmo_d   = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (trig) state_d = ST_START;
            ST_START:    state_d = ST_WAIT_INT;
            ST_WAIT_INT: begin
                if (int_fall) begin
                    state_d = ST_SETTLE;
                end else if (cnt_q == TIMEOUT_LAST) begin
                    state_d = ST_IDLE;
                    tmo_d   = 1'b1;
                end
            end
            ST_SETTLE:   if (cnt_q == SETTLE_LAST) state_d = ST_CAPTURE;
            ST_CAPTURE:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            strobe_n <= 1'b1;
        end else begin
            state_q  <= state_d;
            cnt_q    <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            strobe_n <= (state_d == ST_IDLE);
        end
    end

    assign evt.take    = (state_q == ST_CAPTURE);
    assign evt.timeout = tmo_d;

    // R4: capture is reached only through the settle phase
    capture_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |-> ($past(state_q) == ST_SETTLE));

    // R8: a trigger during a conversion does not start another one
    busy_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && trig) |=> (state_q != ST_START));

    // R7: the wait counter never passes the timeout limit
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_INT) |-> (cnt_q <= TIMEOUT_LAST));

    // R2: strobes are low whenever a conversion is under way
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !strobe_n);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (evt.take) result <= data_in;
            valid <= evt.take;
            err   <= evt.timeout;
        end
    end

    // R5: valid lasts a single cycle
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: a timeout never coincides with a result
    err_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err && valid));

    // R6: result changes only on a capture
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.take |=> $stable(result));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned SETTLE_CYC  = DEF_SETTLE_CYC,
    parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              int_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              sh_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              err
);
    logic     int_lvl_n;
    logic     int_fall;
    logic     strobe_n;
    seq_evt_t evt;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (int_n),
        .level_n (int_lvl_n),
        .fall    (int_fall)
    );

    adc_seq_fsm #(
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .int_fall (int_fall),
        .strobe_n (strobe_n),
        .evt      (evt)
    );

    adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .data_in (adc_data),
        .result  (result),
        .valid   (valid),
        .err     (err)
    );

    assign sh_n = strobe_n;
    assign rd_n = strobe_n;

    // R3: a capture needs the synchronized completion line to be low
    capture_int_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt.take |-> !int_lvl_n);

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DW   = 10;
    localparam int unsigned SETL = 3;
    localparam int unsigned TMO  = 200;
    localparam int unsigned SYNC = 2;
    localparam int unsigned LAT  = SYNC + SETL + 3; // negedges from int_n fall to valid seen

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic          int_n = 1'b1;
    logic [DW-1:0] adc_data = 10'h155;
    logic          sh_n, rd_n, valid, err;
    logic [DW-1:0] result;

    int checks = 0;
    int errors = 0;
    int mode = 0;        // 0 respond, 1 silent
    int resp_delay = 5;
    logic [DW-1:0] next_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(
        .DATA_W(DW), .SETTLE_CYC(SETL), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)
    ) dut_i (
        .clk(clk), .rst(rst), .trig(trig), .int_n(int_n), .adc_data(adc_data),
        .sh_n(sh_n), .rd_n(rd_n), .result(result), .valid(valid), .err(err)
    );

    // Behavioural converter
    initial begin
        forever begin
            @(negedge rd_n);
            if (mode == 0) begin
                repeat (resp_delay) @(posedge clk);
                #3;
                int_n = 1'b0;
                #2;
                adc_data = next_val;
            end
            @(posedge rd_n);
            #1;
            if (mode == 0) int_n = 1'b1;
            adc_data = ~next_val;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic convert(input logic [DW-1:0] v, input int dly);
        int n;
        next_val   = v;
        adc_data   = ~v;
        resp_delay = dly;
        pulse_trig();
        check(sh_n == 1'b0 && rd_n == 1'b0, "R2 strobes low together", {sh_n, rd_n}, 0);
        wait (int_n == 1'b0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!valid && n < 100);
        check(n == LAT, "R4 latency", n, LAT);
        check(result == v, "R4 captured word", result, v);
        check(sh_n && rd_n, "R5 strobes high with valid", {sh_n, rd_n}, 3);
        @(negedge clk);
        check(!valid, "R5 valid one cycle", valid, 0);
        check(result == v, "R6 result held", result, v);
    endtask

    task automatic run_timeout(input string tag);
        int n;
        pulse_trig();
        n = 0;
        while (sh_n == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == TMO + 1, {tag, " strobe low length"}, n, TMO + 1);
        check(err == 1'b1, {tag, " err pulse"}, err, 1);
        check(valid == 1'b0, {tag, " no valid"}, valid, 0);
        @(negedge clk);
        check(err == 1'b0, {tag, " err one cycle"}, err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int vcount;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(sh_n && rd_n, "R1 strobes high", {sh_n, rd_n}, 3);
        check(!valid && !err, "R1 flags low", {valid, err}, 0);
        check(result == '0, "R1 result zero", result, 0);

        // R4 / R5 / R6 exhaustive code sweep with varying delay
        for (int v = 0; v < (1 << DW); v++) begin
            convert(DW'(v), 1 + (v % 40));
        end

        // R7 silent converter
        mode = 1;
        run_timeout("R7");
        // R3 completion line stuck low before start
        int_n = 1'b0;
        repeat (5) @(negedge clk);
        run_timeout("R3");
        int_n = 1'b1;
        mode = 0;
        repeat (5) @(negedge clk);
        convert(10'h2A5, 7);

        // R8 trigger during a conversion
        next_val = 10'h0F3;
        adc_data = ~next_val;
        resp_delay = 20;
        pulse_trig();
        repeat (5) @(negedge clk);
        pulse_trig();
        vcount = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (valid) vcount++;
        end
        check(vcount == 1, "R8 single valid", vcount, 1);
        check(sh_n && rd_n, "R8 strobes idle after", {sh_n, rd_n}, 3);
        check(result == 10'h0F3, "R8 result", result, 10'h0F3);

        finish_run();
    end

endmodule